// File: doc/BRIEF.md
# Combined Multi-Function Custom-Instruction Unit

This block is a coprocessor datapath for a processor's custom-instruction port. It takes two 32-bit operands, a 2-bit function selector and a one-cycle start pulse. It returns one 32-bit result together with a one-cycle done pulse. Behind the port sit four sub-operations. Add, exclusive-or and subtract share one fixed-latency path, in which a chain of flip-flops delays the start pulse. Multiply is an iterative shift-and-add engine whose run time depends on its second operand, and it reports its own completion. The unit ORs the per-path done bits into one completion signal, so the processor sees a single variable-latency handshake.

The result selector is a multiplexer inside the unit, and a register follows it. The wide selection therefore never joins the processor's ALU output path. The selector and both operands are captured on the start cycle. The requester may change or drop them while the operation runs. The protocol is blocking: the requester issues no new start until it has seen done.

Top module: `combo_ci_unit`

## Requirements
- R1: During and after a synchronous reset, done_o is 0 and result_o is 0 until the first operation completes.
- R2: Selector 2'b00 yields the sum opa_i + opb_i modulo 2^32.
- R3: Selector 2'b01 yields the bitwise exclusive-or of opa_i and opb_i.
- R4: Selector 2'b11 yields the difference opa_i - opb_i modulo 2^32.
- R5: Selector 2'b10 yields the low 32 bits of the product opa_i * opb_i.
- R6: For selectors 2'b00, 2'b01 and 2'b11, count the rising edge that samples start_i as edge 1. done_o is then high only during the cycle that follows edge 3.
- R7: For selector 2'b10, done_o is high only during the cycle that follows edge max(popcount(opb_i),1)+2, counted the same way.
- R8: done_o is a one-cycle pulse. result_o changes only in the cycle in which done_o is high, and holds its value afterwards until the next completion.
- R9: Changes to sel_i, opa_i and opb_i after the start cycle have no effect on the running operation's result or latency.
- R10: A reset asserted while an operation is running aborts it. No done pulse follows, and result_o stays 0.
- R11: done_o never asserts unless a start has been accepted since reset and has not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle pulse that launches an operation |
| sel_i | input | 2 | Function: 00 add, 01 xor, 10 multiply, 11 subtract |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (multiplier for selector 10) |
| result_o | output | 32 | Registered result, valid while done_o is high and held afterwards |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A stale or corrupted captured selector would route the wrong sub-result. The bench scrambles all inputs right after start, so this shows as a wrong result_o in the very cycle that done_o pulses. A delay chain of the wrong length, or a multiply iteration counter that is off, shows as done_o arriving one or more edges away from the computed count. A busy flag that is not cleared after completion or reset shows as a second done pulse or a spurious one within a few cycles. The operand sweep covers zero, all-ones, single-bit and dense patterns, so the multiply takes from 1 to 32 iterations.

// File: rtl/combo_ci_pkg.sv
package combo_ci_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_XOR = 2'b01,
    OP_MUL = 2'b10,
    OP_SUB = 2'b11
  } op_sel_e;
endpackage

// File: rtl/combo_fixed_path.sv
// Fixed-latency group: add, xor and subtract are captured at launch; the
// launch pulse walks a flip-flop chain to form this path's done bit.
module combo_fixed_path #(
  parameter int DATA_W  = 32,
  parameter int FIX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum_q,
  output logic [DATA_W-1:0] xor_q,
  output logic [DATA_W-1:0] dif_q,
  output logic              done
);
  // The output register of the unit supplies the last stage of the latency.
  localparam int CHAIN = FIX_LAT - 1;

  logic [CHAIN-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      xor_q <= '0;
      dif_q <= '0;
    end else if (launch) begin
      sum_q <= a + b;
      xor_q <= a ^ b;
      dif_q <= a - b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= launch;
  end

  for (genvar i = 1; i < CHAIN; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[i] <= 1'b0;
      else     chain_q[i] <= chain_q[i-1];
    end
  end

  assign done = chain_q[CHAIN-1];
endmodule

// File: rtl/combo_iter_mul.sv
// Shift-and-add multiplier that handles one set multiplier bit per cycle
// and always takes at least one cycle.
module combo_iter_mul #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] prod_q,
  output logic              done_q
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] mcand_q, mplier_q, acc_q;
  logic              busy_q;
  logic [DATA_W-1:0] lowest, rest, addend;
  logic [IDX_W-1:0]  idx;

  assign lowest = mplier_q & (~mplier_q + 1'b1);
  assign rest   = mplier_q & ~lowest;

  always_comb begin
    idx = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (mplier_q[i]) idx = IDX_W'(i);
    end
  end

  assign addend = (mplier_q != '0) ? (mcand_q << idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        mcand_q  <= a;
        mplier_q <= b;
        acc_q    <= '0;
        busy_q   <= 1'b1;
      end else if (busy_q) begin
        acc_q    <= acc_q + addend;
        mplier_q <= rest;
        if (rest == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign prod_q = acc_q;
endmodule

// File: rtl/combo_out_stage.sv
// Registered result multiplexer and merged completion bit.
module combo_out_stage
  import combo_ci_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  op_sel_e           sel,
  input  logic              fix_done,
  input  logic              mul_done,
  input  logic [DATA_W-1:0] sum_v,
  input  logic [DATA_W-1:0] xor_v,
  input  logic [DATA_W-1:0] dif_v,
  input  logic [DATA_W-1:0] prod_v,
  output logic [DATA_W-1:0] result_q,
  output logic              done_q
);
  logic              any_done;
  logic [DATA_W-1:0] picked;

  assign any_done = fix_done | mul_done;

  always_comb begin
    unique case (sel)
      OP_ADD:  picked = sum_v;
      OP_XOR:  picked = xor_v;
      OP_SUB:  picked = dif_v;
      default: picked = prod_v;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= any_done;
      if (any_done) result_q <= picked;
    end
  end
endmodule

// File: rtl/combo_ci_unit.sv
module combo_ci_unit
  import combo_ci_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FIX_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  op_sel_e           sel_now, sel_q;
  logic              fix_launch, mul_launch, fix_done, mul_done;
  logic [DATA_W-1:0] sum_v, xor_v, dif_v, prod_v;

  assign sel_now    = op_sel_e'(sel_i);
  assign mul_launch = start_i && (sel_now == OP_MUL);
  assign fix_launch = start_i && (sel_now != OP_MUL);

  always_ff @(posedge clk) begin
    if (rst)          sel_q <= OP_ADD;
    else if (start_i) sel_q <= sel_now;
  end

  combo_fixed_path #(.DATA_W(DATA_W), .FIX_LAT(FIX_LAT)) u_fix (
    .clk(clk), .rst(rst), .launch(fix_launch), .a(opa_i), .b(opb_i),
    .sum_q(sum_v), .xor_q(xor_v), .dif_q(dif_v), .done(fix_done)
  );

  combo_iter_mul #(.DATA_W(DATA_W)) u_mul (
    .clk(clk), .rst(rst), .launch(mul_launch), .a(opa_i), .b(opb_i),
    .prod_q(prod_v), .done_q(mul_done)
  );

  combo_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .sel(sel_q), .fix_done(fix_done), .mul_done(mul_done),
    .sum_v(sum_v), .xor_v(xor_v), .dif_v(dif_v), .prod_v(prod_v),
    .result_q(result_o), .done_q(done_o)
  );
endmodule

// File: rtl/combo_ci_checker.sv
module combo_ci_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        sel_i,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (start_i) pend_q <= 1'b1;
    else if (done_o)  pend_q <= 1'b0;
  end

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: the result moves only together with done
  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(result_o)) |-> done_o);

  // R6: fixed-latency operations finish after the third edge
  p_fix_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (start_i && sel_i != 2'b10) |=> !done_o ##1 !done_o ##1 done_o);

  // R7: multiply never finishes before edge 3
  p_mul_min_r7: assert property (@(posedge clk) disable iff (rst)
    (start_i && sel_i == 2'b10) |=> !done_o ##1 !done_o);

  // R11: done only for an accepted, outstanding start
  p_done_owned_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pend_q);
endmodule

bind combo_ci_unit combo_ci_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .sel_i(sel_i),
  .result_o(result_o), .done_o(done_o)
);

// File: tb/test_combo_ci_unit.sv
module test_combo_ci_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  sel_i = 2'b00;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic [31:0] result_o;
  logic        done_o;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  combo_ci_unit i_combo_ci_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .sel_i(sel_i),
    .opa_i(opa_i), .opb_i(opb_i), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hffff_ffff;
      3: return 32'h8000_0000;
      4: return 32'h7fff_ffff;
      5: return 32'h1234_5678;
      6: return 32'ha5a5_a5a5;
      7: return 32'h0000_0003;
      8: return 32'hdead_beef;
      default: return 32'h0000_ffff;
    endcase
  endfunction

  // Inputs are scrambled right after the start cycle (R9).
  task automatic run_op(input logic [1:0] s, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp_r, held;
    int exp_e, e, pc;
    string rq;
    pc = $countones(b);
    case (s)
      2'b00: begin exp_r = a + b; rq = "R2/R9"; end
      2'b01: begin exp_r = a ^ b; rq = "R3/R9"; end
      2'b11: begin exp_r = a - b; rq = "R4/R9"; end
      default: begin exp_r = a * b; rq = "R5/R9"; end
    endcase
    exp_e = (s == 2'b10) ? ((pc < 1 ? 1 : pc) + 2) : 3;
    @(negedge clk);
    start_i = 1'b1; sel_i = s; opa_i = a; opb_i = b;
    @(posedge clk); e = 1;
    @(negedge clk);
    start_i = 1'b0; sel_i = ~s; opa_i = ~a; opb_i = b ^ 32'h5a5a_0f0f;
    while (!done_o && e < 60) begin
      @(posedge clk); e++;
      @(negedge clk);
    end
    chk(done_o && e == exp_e, (s == 2'b10) ? "R7 latency" : "R6 latency", e, exp_e);
    chk(result_o == exp_r, rq, result_o, exp_r);
    held = result_o;
    @(posedge clk); @(negedge clk);
    chk(!done_o, "R8 pulse width", {31'b0, done_o}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk(result_o == held, "R8 hold", result_o, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done_o, "R1 done in reset", {31'b0, done_o}, 32'd0);
    chk(result_o == 32'd0, "R1 result in reset", result_o, 32'd0);
    rst = 1'b0;
    repeat (10) begin
      @(posedge clk); @(negedge clk);
      chk(!done_o, "R11 idle", {31'b0, done_o}, 32'd0);
    end
    chk(result_o == 32'd0, "R1 result after reset", result_o, 32'd0);

    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(2'(s), pat(i), pat(j));

    // R10: abort a long multiply with reset
    @(negedge clk);
    start_i = 1'b1; sel_i = 2'b10; opa_i = 32'h0000_0007; opb_i = 32'hffff_ffff;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    begin
      bit any;
      any = 0;
      repeat (50) begin
        @(posedge clk); @(negedge clk);
        if (done_o) any = 1;
      end
      chk(!any, "R10 no done after abort", {31'b0, any}, 32'd0);
      chk(result_o == 32'd0, "R10 result after abort", result_o, 32'd0);
    end
    run_op(2'b00, 32'h0000_0010, 32'h0000_0020);

    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule